// File: doc/BRIEF.md
# Four-Channel Word DMA Engine with Fill Mode

This block is a memory-to-memory DMA engine with four independent channels. A processor programs each channel through a small word-addressed register port: a start address to read from, a start address to write to, a length in bytes, a constant fill word, and a control word. Setting the start bit hands the channel to the engine. The engine then moves one 32-bit word at a time over a simple request/ready memory master port until the channel's length is used up.

Each channel works in one of two modes. In copy mode it reads a word from the source and writes it to the destination. In fill mode it writes the channel's fill word to the destination and issues no reads. The source and destination addresses can each be held fixed or stepped by 4 after every word. When the last word is written, the channel clears its busy flag and, if enabled, pulses its own interrupt line for one cycle.

A global control bit chooses how busy channels share the bus:
- **Fixed priority:** channel 0 always wins.
- **Round-robin:** the turn passes to the channel after the one served last.

In both cases the choice is made again at every word boundary.

The engine is a four-state machine:
- **ST_IDLE:** takes the arbiter's grant. It moves to ST_READ for a copy, or straight to ST_WRITE for a fill, and stays in ST_IDLE when no channel is busy.
- **ST_READ:** holds a read request until ready, then moves to ST_WRITE.
- **ST_WRITE:** holds a write request until ready, then moves to ST_STEP.
- **ST_STEP:** advances the served channel's addresses and word count for one cycle, then always returns to ST_IDLE.

Top module: `dma4_engine`

## Requirements
- R1: The global control word sits at byte offset 0x00. Channel n's block starts at 0x04 + 0x1C·n and holds these words:
  - +0x00: source address
  - +0x04: destination address
  - +0x08: byte length
  - +0x14: fill word
  - +0x18: control

  All of these read 0 after reset. The words at +0x0C and +0x10 read 0, and writing them changes nothing.
- R2: A write to a source or destination address register loads the channel's working address with bits [1:0] forced to 0. Reading the register returns the working address.
- R3: In copy mode the channel moves length/4 words. Each word is a read of the source followed by a write of that data to the destination. Unfixed addresses advance by 4 per word, so they read back as start + length once the transfer has finished.
- R4: Control bit 14 holds the source address fixed, and control bit 11 holds the destination address fixed.
- R5: With control bit 13 set (fill mode), every destination word receives the fill word and no read access is issued.
- R6: Control bit 31 starts the channel and reads 1 while it is busy. On completion it returns to 0. If control bit 30 is set, irq[n] is high for exactly one cycle; otherwise irq[n] stays low. At most one irq bit is high at a time.
- R7: When global bit 31 is 0, the lowest-numbered busy channel is granted at every word boundary, so a lower channel started later preempts a higher one after its current word.
- R8: When global bit 31 is 1, the grant goes to the first busy channel after the one served last, so two busy channels alternate word by word.
- R9: Writing a control word with bit 31 clear to a busy channel makes the busy bit read 0 from the next cycle. At most the word already in progress is still written, and no interrupt is raised.
- R10: A memory request keeps its address and direction unchanged until mem_ready is sampled high, and every request address is a multiple of 4.
- R11: Starting a channel whose length is below 4 leaves busy at 0, issues no memory access and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access completes in a cycle where this and mem_req are high |
| irq | output | 4 | Per-channel completion pulse |

## Verification
Register writes take effect at the clock edge that samples cfg_we, and reads are combinational, so the bench drives at the falling edge and reads one delay later. A start therefore shows as busy in the very next cycle.

With a zero-wait memory, a copied word needs four cycles (ST_IDLE, ST_READ, ST_WRITE, ST_STEP) and a filled word needs three; each stalled cycle adds one. The busy bit falls and the interrupt pulse appears in the same cycle, after the final ST_STEP edge.

For these reasons the bench does not predict exact completion cycles. It polls busy with a timeout and then waits two further cycles before comparing memory, interrupt counts and read counts. Arbitration order is checked from the logged order of destination writes after a held mem_ready is released.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_STEP
    } xfer_state_e;

    // offsets inside one channel block
    localparam logic [4:0] OFF_SRC  = 5'h00;
    localparam logic [4:0] OFF_DST  = 5'h04;
    localparam logic [4:0] OFF_LEN  = 5'h08;
    localparam logic [4:0] OFF_FILL = 5'h14;
    localparam logic [4:0] OFF_CTRL = 5'h18;

    // control bit positions
    localparam int B_DFIX = 11;
    localparam int B_FILL = 13;
    localparam int B_SFIX = 14;
    localparam int B_IE   = 30;
    localparam int B_GO   = 31;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma4_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [4:0]    off,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] fill_val_o,
    output logic          fill_mode_o,
    output logic          busy_o,
    output logic [AW-1:0] rdata_o,
    output logic          irq_o
);
    logic [AW-1:0] src_q, dst_q, len_q, fill_q;
    logic [AW-3:0] words_q;
    logic          busy_q, ie_q, sfix_q, dfix_q, fmode_q, irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            fill_q  <= '0;
            words_q <= '0;
            busy_q  <= 1'b0;
            ie_q    <= 1'b0;
            sfix_q  <= 1'b0;
            dfix_q  <= 1'b0;
            fmode_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (step && busy_q) begin
                if (!sfix_q) src_q <= src_q + AW'(4);
                if (!dfix_q) dst_q <= dst_q + AW'(4);
                words_q <= words_q - 1'b1;
                if (words_q == (AW-2)'(1)) begin
                    busy_q <= 1'b0;
                    irq_q  <= ie_q;
                end
            end
            if (wr_en) begin
                case (off)
                    OFF_SRC:  src_q  <= {wdata[AW-1:2], 2'b00};
                    OFF_DST:  dst_q  <= {wdata[AW-1:2], 2'b00};
                    OFF_LEN:  len_q  <= wdata;
                    OFF_FILL: fill_q <= wdata;
                    OFF_CTRL: begin
                        dfix_q  <= wdata[B_DFIX];
                        fmode_q <= wdata[B_FILL];
                        sfix_q  <= wdata[B_SFIX];
                        ie_q    <= wdata[B_IE];
                        busy_q  <= wdata[B_GO] && (len_q[AW-1:2] != '0);
                        if (wdata[B_GO]) words_q <= len_q[AW-1:2];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (off)
            OFF_SRC:  rdata_o = src_q;
            OFF_DST:  rdata_o = dst_q;
            OFF_LEN:  rdata_o = len_q;
            OFF_FILL: rdata_o = fill_q;
            OFF_CTRL: begin
                rdata_o[B_GO]   = busy_q;
                rdata_o[B_IE]   = ie_q;
                rdata_o[B_SFIX] = sfix_q;
                rdata_o[B_FILL] = fmode_q;
                rdata_o[B_DFIX] = dfix_q;
            end
            default: rdata_o = '0;
        endcase
    end

    assign src_o       = src_q;
    assign dst_o       = dst_q;
    assign fill_val_o  = fill_q;
    assign fill_mode_o = fmode_q;
    assign busy_o      = busy_q;
    assign irq_o       = irq_q;
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NCH = 4,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           rr_mode,
    input  logic           adv,
    input  logic [CW-1:0]  adv_ch,
    output logic           grant_valid,
    output logic [CW-1:0]  grant_ch
);
    logic [CW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv)
            ptr_q <= (int'(adv_ch) == NCH-1) ? '0 : adv_ch + 1'b1;
    end

    // descending scan: the last hit assigned is the preferred one
    always_comb begin
        grant_valid = 1'b0;
        grant_ch    = '0;
        for (int i = NCH-1; i >= 0; i--) begin
            int idx;
            idx = rr_mode ? int'(ptr_q) + i : i;
            if (idx >= NCH) idx = idx - NCH;
            if (req[idx]) begin
                grant_valid = 1'b1;
                grant_ch    = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grant_valid,
    input  logic [CW-1:0]           grant_ch,
    input  logic [NCH-1:0][AW-1:0]  src_all,
    input  logic [NCH-1:0][AW-1:0]  dst_all,
    input  logic [NCH-1:0][DW-1:0]  fill_all,
    input  logic [NCH-1:0]          fmode_all,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_ready,
    output logic                    step,
    output logic [CW-1:0]           step_ch
);
    xfer_state_e   state_q, state_d;
    logic [CW-1:0] cur_q;
    logic [DW-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grant_valid)
                          state_d = fmode_all[grant_ch] ? ST_WRITE : ST_READ;
            ST_READ:  if (mem_ready) state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = ST_STEP;
            ST_STEP:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            buf_q <= '0;
        end else begin
            if (state_q == ST_IDLE && grant_valid) cur_q <= grant_ch;
            if (state_q == ST_READ && mem_ready)   buf_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        step      = 1'b0;
        step_ch   = cur_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_all[cur_q];
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_all[cur_q];
                mem_wdata = fmode_all[cur_q] ? fill_all[cur_q] : buf_q;
            end
            ST_STEP: step = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [31:0]    cfg_wdata,
    output logic [31:0]    cfg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ready,
    output logic [NCH-1:0] irq
);
    localparam int CW     = $clog2(NCH);
    localparam int BLK    = 28;
    localparam int FIRST  = 4;

    logic                   rr_q;
    logic [NCH-1:0][AW-1:0] src_all, dst_all;
    logic [NCH-1:0][31:0]   fill_all, rd_all;
    logic [NCH-1:0]         fmode_all, busy_all, hit_all;
    logic                   grant_valid, step;
    logic [CW-1:0]          grant_ch, step_ch;

    always_ff @(posedge clk) begin
        if (!rst_n)                       rr_q <= 1'b0;
        else if (cfg_we && cfg_addr == '0) rr_q <= cfg_wdata[31];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [RAW-1:0] BASE = RAW'(FIRST + BLK*g);
        logic [4:0] off;
        assign hit_all[g] = (cfg_addr >= BASE) && (cfg_addr < BASE + RAW'(BLK));
        assign off        = 5'(cfg_addr - BASE);

        dma_chan_regs #(.AW(AW)) regs_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (cfg_we && hit_all[g]),
            .off         (off),
            .wdata       (cfg_wdata),
            .step        (step && step_ch == CW'(g)),
            .src_o       (src_all[g]),
            .dst_o       (dst_all[g]),
            .fill_val_o  (fill_all[g]),
            .fill_mode_o (fmode_all[g]),
            .busy_o      (busy_all[g]),
            .rdata_o     (rd_all[g]),
            .irq_o       (irq[g])
        );
    end

    always_comb begin
        cfg_rdata = (cfg_addr == '0) ? {rr_q, 31'b0} : '0;
        for (int i = 0; i < NCH; i++)
            if (hit_all[i]) cfg_rdata = rd_all[i];
    end

    dma_arbiter #(.NCH(NCH), .CW(CW)) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (busy_all),
        .rr_mode     (rr_q),
        .adv         (step),
        .adv_ch      (step_ch),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch)
    );

    dma_xfer_fsm #(.NCH(NCH), .AW(AW), .DW(32), .CW(CW)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch),
        .src_all     (src_all),
        .dst_all     (dst_all),
        .fill_all    (fill_all),
        .fmode_all   (fmode_all),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .step        (step),
        .step_ch     (step_ch)
    );
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
    parameter int NCH = 4,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_ready,
    input logic [NCH-1:0] irq
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R3
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |=> (irq == '0));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));
endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH), .AW(AW)) chk_i (.*);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic [31:0] fillv;
        logic        sfix;
        logic        dfix;
        logic        fm;
        logic        ie;
        logic        slow;
    } vec_t;

    // ch, src, dst, len, fill, sfix, dfix, fill-mode, ie, slow memory
    localparam vec_t VECS [7] = '{
        '{2'd0, 32'h000, 32'h200, 32'd32, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd2, 32'h010, 32'h240, 32'd20, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd3, 32'h000, 32'h300, 32'd24, 32'hDEADBEEF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd1, 32'h020, 32'h280, 32'd16, 32'h0,        1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd0, 32'h040, 32'h3F0, 32'd12, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd2, 32'h000, 32'h2C0, 32'd8,  32'h12345678, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd3, 32'h053, 32'h343, 32'd8,  32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  irq;

    logic        hold = 1'b0;
    logic        slow = 1'b0;
    logic        cyc = 1'b0;
    logic [31:0] mem [256];
    int          wlog [512];
    int          wr_total = 0;
    int          rd_total = 0;
    int          irq_cnt [4] = '{0, 0, 0, 0};
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma4_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
    );

    assign mem_ready = mem_req && !hold && !(slow && cyc);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        cyc <= ~cyc;
        for (int c = 0; c < 4; c++) if (irq[c]) irq_cnt[c] = irq_cnt[c] + 1;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] = mem_wdata;
                wlog[wr_total % 512] = (mem_addr[9:2] >= 8'd160) ? 1 : 0;
                wr_total = wr_total + 1;
            end else begin
                rd_total = rd_total + 1;
            end
        end
    end

    function automatic logic [31:0] init_word(int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    function automatic logic [7:0] base(int ch);
        return 8'(4 + 28 * ch);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic mem_init();
        for (int i = 0; i < 256; i++) mem[i] = init_word(i);
    endtask

    task automatic wait_idle(int ch);
        logic [31:0] c;
        int t = 0;
        do begin
            rd(base(ch) + 8'h18, c);
            t++;
        end while (c[31] && t < 3000);
        repeat (2) @(posedge clk);
    endtask

    task automatic run_vec(vec_t v);
        logic [31:0] expm [256];
        logic [31:0] s, d, got;
        int ch = int'(v.ch);
        int irq0, rd0, bad_i;
        for (int i = 0; i < 256; i++) expm[i] = init_word(i);
        mem_init();
        slow = v.slow;
        wr(base(ch) + 8'h00, v.src);
        wr(base(ch) + 8'h04, v.dst);
        wr(base(ch) + 8'h08, v.len);
        wr(base(ch) + 8'h14, v.fillv);
        irq0 = irq_cnt[ch];
        rd0  = rd_total;
        wr(base(ch) + 8'h18, {1'b1, v.ie, 15'b0, v.sfix, v.fm, 1'b0, v.dfix, 11'b0});
        wait_idle(ch);
        slow = 1'b0;
        s = v.src & ~32'h3;
        d = v.dst & ~32'h3;
        for (int k = 0; k < int'(v.len / 4); k++) begin
            expm[d[9:2]] = v.fm ? v.fillv : init_word(int'(s[9:2]));
            if (!v.sfix) s = s + 4;
            if (!v.dfix) d = d + 4;
        end
        bad_i = -1;
        for (int i = 255; i >= 0; i--) if (mem[i] !== expm[i]) bad_i = i;
        if (bad_i < 0) check(1'b1, "R3/R4/R5 memory image", 0, 0);
        else check(1'b0, "R3/R4/R5 memory image", mem[bad_i], expm[bad_i]);
        check(irq_cnt[ch] - irq0 == (v.ie ? 1 : 0), "R6 irq count", irq_cnt[ch] - irq0, v.ie ? 1 : 0);
        check(rd_total - rd0 == (v.fm ? 0 : int'(v.len / 4)), "R5 read count",
              rd_total - rd0, v.fm ? 0 : v.len / 4);
        rd(base(ch) + 8'h00, got);
        check(got == s, "R2/R3/R4 source readback", got, s);
        rd(base(ch) + 8'h04, got);
        check(got == d, "R2/R3/R4 destination readback", got, d);
        rd(base(ch) + 8'h18, got);
        check(got[31] == 1'b0, "R6 busy cleared", got, got & 32'h7FFF_FFFF);
    endtask

    task automatic arb_test(bit rr, int first, int second, int exp_seq [8], string tag);
        int w0;
        bit ok = 1'b1;
        logic [31:0] got_seq = '0, exp_bits = '0;
        wr(8'h00, {rr, 31'b0});
        for (int c = 0; c < 2; c++) begin
            wr(base(c) + 8'h04, c == 0 ? 32'h200 : 32'h280);
            wr(base(c) + 8'h08, 32'd16);
            wr(base(c) + 8'h14, 32'hF0F0_0000 + 32'(c));
        end
        hold = 1'b1;
        w0 = wr_total;
        wr(base(first) + 8'h18, 32'h0000_2000 | 32'h8000_0000);
        wr(base(second) + 8'h18, 32'h0000_2000 | 32'h8000_0000);
        @(negedge clk);
        hold = 1'b0;
        wait_idle(0);
        wait_idle(1);
        for (int k = 0; k < 8; k++) begin
            got_seq[k] = wlog[(w0 + k) % 512][0];
            exp_bits[k] = exp_seq[k][0];
            if (wlog[(w0 + k) % 512] != exp_seq[k]) ok = 1'b0;
        end
        check(ok && (wr_total - w0 == 8), tag, got_seq, exp_bits);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int i0, w0;
        mem_init();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(irq == 4'b0 && mem_req == 1'b0, "R1 reset outputs", {27'b0, mem_req, irq}, 0);
        rd(8'h00, got);
        check(got == 0, "R1 global reset", got, 0);
        for (int c = 0; c < 4; c++) begin
            rd(base(c) + 8'h18, got);
            check(got == 0, "R1 ctrl reset", got, 0);
            rd(base(c) + 8'h00, got);
            check(got == 0, "R1 src reset", got, 0);
        end
        // R1 reserved words ignored
        wr(base(0) + 8'h0C, 32'hFFFF_FFFF);
        wr(base(0) + 8'h10, 32'hFFFF_FFFF);
        rd(base(0) + 8'h0C, got);
        check(got == 0, "R1 reserved word reads zero", got, 0);
        rd(base(0) + 8'h08, got);
        check(got == 0, "R1 reserved write leaves length", got, 0);
        // R2 unaligned address load
        wr(base(2) + 8'h04, 32'h1234_5677);
        rd(base(2) + 8'h04, got);
        check(got == 32'h1234_5674, "R2 low bits cleared", got, 32'h1234_5674);

        // R3 R4 R5 R6 vector walk
        foreach (VECS[i]) run_vec(VECS[i]);

        // R7 fixed priority: ch1 starts first, ch0 preempts after one word
        arb_test(1'b0, 1, 0, '{1, 0, 0, 0, 0, 1, 1, 1}, "R7 fixed priority order");
        // R8 round-robin alternation
        arb_test(1'b1, 0, 1, '{0, 1, 0, 1, 0, 1, 0, 1}, "R8 round-robin order");
        wr(8'h00, 32'h0);

        // R9 abort mid-transfer
        wr(base(1) + 8'h00, 32'h000);
        wr(base(1) + 8'h04, 32'h280);
        wr(base(1) + 8'h08, 32'd128);
        i0 = irq_cnt[1];
        wr(base(1) + 8'h18, 32'hC000_0000);
        repeat (10) @(posedge clk);
        wr(base(1) + 8'h18, 32'h4000_0000);
        w0 = wr_total;
        rd(base(1) + 8'h18, got);
        check(got[31] == 1'b0, "R9 busy drops on abort", got, 32'h4000_0000);
        repeat (20) @(posedge clk);
        check(wr_total - w0 <= 1, "R9 at most one word after abort", wr_total - w0, 1);
        check(irq_cnt[1] == i0, "R9 no irq on abort", irq_cnt[1] - i0, 0);

        // R11 zero length start
        wr(base(3) + 8'h08, 32'd3);
        i0 = irq_cnt[3];
        w0 = wr_total + rd_total;
        wr(base(3) + 8'h18, 32'hC000_0000);
        rd(base(3) + 8'h18, got);
        check(got[31] == 1'b0, "R11 busy stays low", got, 32'h4000_0000);
        repeat (8) @(posedge clk);
        check(wr_total + rd_total == w0 && irq_cnt[3] == i0, "R11 no access no irq",
              wr_total + rd_total - w0, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule